// File: doc/BRIEF.md
# Burst Column Order Sequencer

This block produces the order in which column positions are visited during one eight-slot memory burst. A start pulse captures the starting column (three low address bits), the ordering mode (linear wrap or XOR), the length mode (full eight-beat burst or chopped four-beat burst) and the direction (read or write). For the next eight clock cycles the block presents one slot per cycle. Each slot carries a column index, a flag that marks real data and a flag that says whether the data bus is driven. One cycle after the last slot, a single-cycle completion pulse follows.

A chopped burst takes the same eight slots as a full burst. Only the data-valid and drive flags show which slots carry data. In the four unused slots of a chopped read the bus is released. In the four unused slots of a chopped write the bus stays driven but the data is ignored. Writes always use a fixed, aligned order no matter what the starting column is. Each slot lasts one clock, so the model runs at a single data rate. Strobe generation, latency timing and the data path belong to other blocks.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, busy_o, done_o, beat_valid_o and drive_en_o are 0 and col_idx_o is 0.
- R2: If start_i is 1 at a clock edge while busy_o is 0, busy_o is 1 for the next 8 cycles (slots 0..7, one per cycle). In the cycle after those 8, done_o is 1 for exactly one cycle while busy_o is 0.
- R3: A start_i pulse while busy_o is 1 is ignored: the running burst is neither restarted nor lengthened, and no extra burst follows it.
- R4: A full read (chop_i=0, write_i=0) with interleave_i=0 and start column c outputs, in slot n, the bits {c[2]^n[2], (c[1:0]+n[1:0]) mod 4}. For example, c=1 gives 1,2,3,0,5,6,7,4.
- R5: A full read with interleave_i=1 outputs c XOR n in slot n. For example, c=5 gives 5,4,7,6,1,0,3,2.
- R6: A full write (chop_i=0, write_i=1) outputs 0,1,2,3,4,5,6,7 whatever the values of start_col_i and interleave_i. All 8 slots have beat_valid_o=1 and drive_en_o=1.
- R7: A chopped read (chop_i=1, write_i=0) outputs in slots 0..3 the same columns as the full read in the selected mode, so the columns wrap inside the group of four chosen by c[2]. These slots have beat_valid_o=1 and drive_en_o=1. In slots 4..7, beat_valid_o=0 and drive_en_o=0 (bus released).
- R8: A chopped write (chop_i=1, write_i=1) outputs {c[2], n[1:0]} in slots 0..3, ignoring c[1:0], with beat_valid_o=1. In slots 4..7, beat_valid_o=0 and drive_en_o stays 1 (data is ignored).
- R9: col_idx_o is 0 in every slot with beat_valid_o=0. While busy_o is 0, beat_valid_o, drive_en_o and col_idx_o are all 0.
- R10: All control inputs are captured only on an accepted start. Changing them during a burst has no effect on its slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst start strobe |
| start_col_i | input | 3 | Starting column low bits |
| interleave_i | input | 1 | 1 = XOR order, 0 = linear wrap order |
| chop_i | input | 1 | 1 = chopped four-beat burst, 0 = full eight-beat burst |
| write_i | input | 1 | 1 = write, 0 = read |
| busy_o | output | 1 | High while the eight slots run |
| col_idx_o | output | 3 | Column index for the current slot |
| beat_valid_o | output | 1 | Slot carries real data |
| drive_en_o | output | 1 | Data bus driven in this slot |
| done_o | output | 1 | One-cycle pulse after the last slot |

## Verification
On every cycle the assertions check the following. The burst length is bounded and a restart mid-burst cannot stretch it. The completion pulse lasts one cycle and only follows exactly eight busy cycles. Idle outputs are quiet. A valid beat is always driven. Once the bus is released within a burst, it is never driven again in that burst. The column orders under each combination of mode, length and direction, the aligned write orders that ignore the start column, and the immunity to control changes mid-burst can only be shown by the bench's scenarios, which compare every slot against an independently computed order.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned SLOTS = 8;
  localparam int unsigned COL_W = $clog2(SLOTS);

  typedef struct packed {
    logic [COL_W-1:0] col;
    logic             intlv;
    logic             chop;
    logic             wr;
  } burst_cmd_t;
endpackage

// File: rtl/burst_slot_ctrl.sv
module burst_slot_ctrl
  import burst_seq_pkg::*;
#(
  parameter int unsigned N_SLOTS = SLOTS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  output logic                       load_o,
  output logic                       busy_o,
  output logic [$clog2(N_SLOTS)-1:0] slot_o,
  output logic                       done_o
);
  localparam int unsigned SW = $clog2(N_SLOTS);
  localparam logic [SW-1:0] LAST = SW'(N_SLOTS - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          load;

  assign load = start_i & ~busy_q;

  always_comb begin
    busy_d = busy_q;
    slot_d = slot_q;
    done_d = 1'b0;
    if (load) begin
      busy_d = 1'b1;
      slot_d = '0;
    end else if (busy_q) begin
      if (slot_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        slot_d = '0;
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      slot_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      slot_q <= slot_d;
    end
  end

  assign load_o = load;
  assign busy_o = busy_q;
  assign slot_o = slot_q;
  assign done_o = done_q;
endmodule

// File: rtl/burst_slot_order.sv
module burst_slot_order
  import burst_seq_pkg::*;
(
  input  burst_cmd_t       cmd_i,
  input  logic [COL_W-1:0] slot_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             drive_o
);
  localparam int unsigned MSB = COL_W - 1;

  logic             first_half;
  logic [COL_W-1:0] lin_col;
  logic [COL_W-1:0] xor_col;
  logic [COL_W-1:0] rd_col;
  logic [MSB-1:0]   low_sum;

  assign first_half = ~slot_i[MSB];
  assign low_sum    = cmd_i.col[MSB-1:0] + slot_i[MSB-1:0];
  assign lin_col    = {cmd_i.col[MSB] ^ slot_i[MSB], low_sum};
  assign xor_col    = cmd_i.col ^ slot_i;
  assign rd_col     = cmd_i.intlv ? xor_col : lin_col;

  always_comb begin
    col_o   = '0;
    valid_o = 1'b0;
    drive_o = 1'b0;
    if (cmd_i.wr) begin
      drive_o = 1'b1;
      if (!cmd_i.chop) begin
        col_o   = slot_i;
        valid_o = 1'b1;
      end else if (first_half) begin
        col_o   = {cmd_i.col[MSB], slot_i[MSB-1:0]};
        valid_o = 1'b1;
      end
    end else if (!cmd_i.chop || first_half) begin
      col_o   = rd_col;
      valid_o = 1'b1;
      drive_o = 1'b1;
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             interleave_i,
  input  logic             chop_i,
  input  logic             write_i,
  output logic             busy_o,
  output logic [COL_W-1:0] col_idx_o,
  output logic             beat_valid_o,
  output logic             drive_en_o,
  output logic             done_o
);
  logic             load;
  logic             busy;
  logic [COL_W-1:0] slot;
  burst_cmd_t       cmd_q, cmd_d;
  logic [COL_W-1:0] ord_col;
  logic             ord_valid;
  logic             ord_drive;

  burst_slot_ctrl #(.N_SLOTS(SLOTS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .load_o (load),
    .busy_o (busy),
    .slot_o (slot),
    .done_o (done_o)
  );

  always_comb begin
    cmd_d = cmd_q;
    if (load) begin
      cmd_d.col   = start_col_i;
      cmd_d.intlv = interleave_i;
      cmd_d.chop  = chop_i;
      cmd_d.wr    = write_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  burst_slot_order u_order (
    .cmd_i  (cmd_q),
    .slot_i (slot),
    .col_o  (ord_col),
    .valid_o(ord_valid),
    .drive_o(ord_drive)
  );

  assign busy_o       = busy;
  assign col_idx_o    = busy ? ord_col : '0;
  assign beat_valid_o = busy & ord_valid;
  assign drive_en_o   = busy & ord_drive;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk
  import burst_seq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic [COL_W-1:0] col_idx_o,
  input logic             beat_valid_o,
  input logic             drive_en_o,
  input logic             done_o
);
  logic [COL_W:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> run_q < (COL_W+1)'(SLOTS));

  assert_done_after_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_q == (COL_W+1)'(SLOTS)) && !busy_o);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !beat_valid_o && !drive_en_o && (col_idx_o == '0));

  assert_invalid_zero_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid_o |-> col_idx_o == '0);

  assert_valid_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o |-> drive_en_o);

  assert_release_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$past(drive_en_o)) |-> !drive_en_o);
endmodule

bind burst_col_seq burst_col_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .col_idx_o   (col_idx_o),
  .beat_valid_o(beat_valid_o),
  .drive_en_o  (drive_en_o),
  .done_o      (done_o)
);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [2:0] start_col_i;
  logic       interleave_i;
  logic       chop_i;
  logic       write_i;
  logic       busy_o;
  logic [2:0] col_idx_o;
  logic       beat_valid_o;
  logic       drive_en_o;
  logic       done_o;

  typedef struct packed {
    logic [2:0] col;
    logic       valid;
    logic       drive;
    logic       busy;
    logic       done;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int    total = 0;
  int    bad   = 0;
  int    cycles = 0;

  burst_col_seq u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Slot model derived from the requirements
  function automatic item_t model(bit [2:0] c, bit il, bit ch, bit wr, int n);
    item_t it;
    it.busy = 1'b1; it.done = 1'b0;
    it.col = 3'd0; it.valid = 1'b0; it.drive = 1'b0;
    if (wr) begin
      it.drive = 1'b1;
      if (!ch) begin it.col = 3'(n); it.valid = 1'b1; end
      else if (n < 4) begin it.col = 3'((c & 4) | n); it.valid = 1'b1; end
    end else if (!ch || n < 4) begin
      it.valid = 1'b1; it.drive = 1'b1;
      if (il) it.col = c ^ 3'(n);
      else    it.col = 3'(((c & 4) ^ (n & 4)) | ((c + n) & 3));
    end
    return it;
  endfunction

  function automatic string req_of(bit il, bit ch, bit wr);
    if (wr)  return ch ? "R8" : "R6";
    if (ch)  return "R7";
    return il ? "R5" : "R4";
  endfunction

  // Monitor: compare every active cycle against the scoreboard
  always @(negedge clk) begin
    if (rst_n && (busy_o || done_o)) begin
      item_t act;
      act = '{col: col_idx_o, valid: beat_valid_o, drive: drive_en_o,
              busy: busy_o, done: done_o};
      total = total + 1;
      if (exp_q.size() == 0) begin
        bad = bad + 1;
        $display("FAIL R3 unexpected activity: act=%b exp=idle", act);
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          bad = bad + 1;
          $display("FAIL %s/R10 slot: act col=%0d v=%b d=%b busy=%b done=%b exp col=%0d v=%b d=%b busy=%b done=%b",
                   t, act.col, act.valid, act.drive, act.busy, act.done,
                   e.col, e.valid, e.drive, e.busy, e.done);
        end
      end
    end
  end

  task automatic run_burst(bit [2:0] c, bit il, bit ch, bit wr, bit poke);
    @(negedge clk);
    start_i = 1'b1; start_col_i = c; interleave_i = il; chop_i = ch; write_i = wr;
    for (int n = 0; n < 8; n++) begin
      exp_q.push_back(model(c, il, ch, wr, n));
      tag_q.push_back(req_of(il, ch, wr));
    end
    exp_q.push_back('{col: 3'd0, valid: 1'b0, drive: 1'b0, busy: 1'b0, done: 1'b1});
    tag_q.push_back("R2");
    @(negedge clk);
    start_i = 1'b0;
    // R10: disturb controls while the burst runs
    start_col_i = ~c; interleave_i = ~il; chop_i = ~ch; write_i = ~wr;
    if (poke) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;   // R3: start while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    repeat (14) @(negedge clk);
    total = total + 1;
    if (exp_q.size() != 0) begin
      bad = bad + 1;
      $display("FAIL R2 burst incomplete: act=%0d pending exp=0", exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; start_col_i = 3'd0;
    interleave_i = 1'b0; chop_i = 1'b0; write_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total = total + 1;
    if (busy_o !== 1'b0 || done_o !== 1'b0 || beat_valid_o !== 1'b0 ||
        drive_en_o !== 1'b0 || col_idx_o !== 3'd0) begin
      bad = bad + 1;
      $display("FAIL R1 reset: act=%b%b%b%b%0d exp=00000",
               busy_o, done_o, beat_valid_o, drive_en_o, col_idx_o);
    end
    run_burst(3'd1, 1'b0, 1'b0, 1'b0, 1'b0); // R4
    run_burst(3'd6, 1'b0, 1'b0, 1'b0, 1'b0); // R4
    run_burst(3'd5, 1'b1, 1'b0, 1'b0, 1'b0); // R5
    run_burst(3'd2, 1'b1, 1'b0, 1'b0, 1'b0); // R5
    run_burst(3'd5, 1'b0, 1'b0, 1'b1, 1'b0); // R6
    run_burst(3'd3, 1'b1, 1'b0, 1'b1, 1'b0); // R6
    run_burst(3'd2, 1'b0, 1'b1, 1'b0, 1'b0); // R7
    run_burst(3'd5, 1'b0, 1'b1, 1'b0, 1'b0); // R7
    run_burst(3'd7, 1'b1, 1'b1, 1'b0, 1'b0); // R7
    run_burst(3'd6, 1'b0, 1'b1, 1'b1, 1'b0); // R8
    run_burst(3'd1, 1'b1, 1'b1, 1'b1, 1'b0); // R8
    run_burst(3'd4, 1'b0, 1'b0, 1'b0, 1'b1); // R3
    run_burst(3'd3, 1'b1, 1'b1, 1'b0, 1'b1); // R3
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule